// File: doc/BRIEF.md
# Paravirtual Device Control Register Bank

This block is the byte-addressed control header of a paravirtual device function, in the older port-style register layout. A host bus adapter presents single-cycle read and write requests (address, data, size, strobe). The block decodes them against a fixed header. The header holds the feature words, a queue selector with a page-frame number per queue, device status, a read-to-clear interrupt status byte and, when message-signalled interrupts are enabled, interrupt vector numbers. Read data is combinational in the request cycle. Register updates and side effects take effect at the clock edge that ends the request.

Any address at or above the end of the header goes to a device-specific configuration window. The request is forwarded with the address made relative to the window base. That base is 20 when message-signalled interrupts are off and 24 when they are on, because the two vector registers then occupy offsets 20 and 22. The block raises a level interrupt output and a one-cycle queue-notify pulse carrying the queue index. It also raises a one-cycle device-reset pulse when software writes zero to the status byte or to the page-frame number.

Top module: `vio_regbank`

## Requirements
- R1: A read at offset 0 returns `dev_feat_i` with bits 24, 28 and 30 forced to 1. Writes to offset 0 and offset 12 are dropped.
- R2: Offset 4 holds the 32-bit guest feature word. A write with bit 30 set stores `fallback_feat_i` instead of the written value.
- R3: A write to offset 14 selects the queue only when the value is below NUM_Q, and is otherwise ignored. Offset 8 reads and writes the page-frame number of the selected queue. Offset 12 reads QDEPTH.
- R4: Writing a value whose low byte is zero to offset 18, or writing zero to offset 8, resets the device. Guest features, status, ISR, queue select and all page-frame numbers become 0, and all vectors become 0xFFFF. `dev_rst_o` is high for the one following cycle.
- R5: Offset 18 keeps the low 8 bits of a write. While `bm_off_i` is high, status bit 2 is cleared, and this takes priority over a write.
- R6: The ISR byte at offset 19 gets bit 0 set by `q_intr_i`, and bits 0 and 1 set by `cfg_chg_i`. A read returns the current value and clears the byte at the end of the access. An event in the same cycle as the read is kept.
- R7: `irq_o` equals ISR bit 0 when `msix_en_i` is low and is 0 when it is high. It drops in the cycle after an ISR read.
- R8: A write to offset 16 produces `notify_o` high for exactly the following cycle, with `notify_idx_o` equal to the low 16 bits written. No register changes.
- R9: With `msix_en_i` high, offset 20 is the config-change vector and offset 22 the vector of the selected queue. A written value not below NUM_VEC stores 0xFFFF. The reset value is 0xFFFF.
- R10: Header reads at offsets that start no register return 0xFFFFFFFF. Accesses at or above the window base (20, or 24 with `msix_en_i` high) assert `cfg_req_o` with `cfg_addr_o` = address minus base, and return `cfg_rdata_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Access strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | AW | Byte offset |
| size_i | input | 2 | Access size, forwarded to the window |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, same cycle |
| msix_en_i | input | 1 | Message-signalled interrupts enabled |
| dev_feat_i | input | 32 | Device feature mask |
| fallback_feat_i | input | 32 | Value stored on a bad-feature write |
| q_intr_i | input | 1 | Queue interrupt event |
| cfg_chg_i | input | 1 | Configuration change event |
| bm_off_i | input | 1 | Bus mastering disabled |
| irq_o | output | 1 | Legacy level interrupt |
| notify_o | output | 1 | Queue notify pulse |
| notify_idx_o | output | 16 | Notified queue index |
| dev_rst_o | output | 1 | Device reset pulse |
| cfg_req_o | output | 1 | Window access strobe |
| cfg_we_o | output | 1 | Window write |
| cfg_addr_o | output | AW | Window-relative offset |
| cfg_size_o | output | 2 | Window access size |
| cfg_wdata_o | output | 32 | Window write data |
| cfg_rdata_i | input | 32 | Window read data |

## Verification
The bench targets the moving window base. A decoder that ignored `msix_en_i` would return window data at offset 20 with vectors enabled, or vector data with them disabled. It checks that an out-of-range queue select leaves the old selection in place, so a design that truncated the value would switch queues. It drives an interrupt event in the same cycle as an ISR read, where a clear-wins design would lose the event. It also checks the same-cycle effects of each reset trigger: a status write of 0x100 must reset because only the low byte counts, and vectors must return to 0xFFFF rather than zero.

// File: rtl/vio_regbank.sv
module vio_regbank #(
  parameter int NUM_Q   = 4,
  parameter int NUM_VEC = 3,
  parameter int QDEPTH  = 128,
  parameter int AW      = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [1:0]    size_i,
  input  logic [31:0]   wdata_i,
  output logic [31:0]   rdata_o,
  input  logic          msix_en_i,
  input  logic [31:0]   dev_feat_i,
  input  logic [31:0]   fallback_feat_i,
  input  logic          q_intr_i,
  input  logic          cfg_chg_i,
  input  logic          bm_off_i,
  output logic          irq_o,
  output logic          notify_o,
  output logic [15:0]   notify_idx_o,
  output logic          dev_rst_o,
  output logic          cfg_req_o,
  output logic          cfg_we_o,
  output logic [AW-1:0] cfg_addr_o,
  output logic [1:0]    cfg_size_o,
  output logic [31:0]   cfg_wdata_o,
  input  logic [31:0]   cfg_rdata_i
);
  localparam int QW = (NUM_Q > 1) ? $clog2(NUM_Q) : 1;
  localparam logic [AW-1:0] A_HFEAT = AW'(0);
  localparam logic [AW-1:0] A_GFEAT = AW'(4);
  localparam logic [AW-1:0] A_PFN   = AW'(8);
  localparam logic [AW-1:0] A_QSZ   = AW'(12);
  localparam logic [AW-1:0] A_QSEL  = AW'(14);
  localparam logic [AW-1:0] A_NOTE  = AW'(16);
  localparam logic [AW-1:0] A_STAT  = AW'(18);
  localparam logic [AW-1:0] A_ISR   = AW'(19);
  localparam logic [AW-1:0] A_CVEC  = AW'(20);
  localparam logic [AW-1:0] A_QVEC  = AW'(22);
  localparam logic [AW-1:0] BASE_LO = AW'(20);
  localparam logic [AW-1:0] BASE_HI = AW'(24);
  localparam logic [31:0] FIXED_FEAT = (32'd1 << 24) | (32'd1 << 28) | (32'd1 << 30);
  localparam int BAD_BIT = 30;
  localparam int DRV_OK  = 2;
  localparam logic [15:0] NO_VEC = 16'hFFFF;
  localparam logic [15:0] NV16   = 16'(NUM_VEC);
  localparam logic [31:0] NQ32   = 32'(NUM_Q);
  localparam logic [15:0] QSZ16  = 16'(QDEPTH);

  logic [31:0]   gfeat;
  logic [31:0]   pfn  [NUM_Q];
  logic [15:0]   qvec [NUM_Q];
  logic [15:0]   cvec;
  logic [QW-1:0] qsel;
  logic [7:0]    status, isr, isr_set;
  logic          notify_q, rst_q;
  logic [15:0]   nidx_q;

  logic [AW-1:0] base;
  logic          hdr, wr, rd, dev_clr, vec_ok;
  logic [15:0]   vec_val;

  assign base    = msix_en_i ? BASE_HI : BASE_LO;
  assign hdr     = addr_i < base;
  assign wr      = req_i & we_i & hdr;
  assign rd      = req_i & ~we_i & hdr;
  assign dev_clr = wr & (((addr_i == A_STAT) & (wdata_i[7:0] == 8'h00)) |
                         ((addr_i == A_PFN) & (wdata_i == 32'h0)));
  assign vec_val = wdata_i[15:0];
  assign vec_ok  = vec_val < NV16;
  assign isr_set = {6'b0, cfg_chg_i, q_intr_i | cfg_chg_i};

  assign cfg_req_o   = req_i & ~hdr;
  assign cfg_we_o    = we_i;
  assign cfg_addr_o  = addr_i - base;
  assign cfg_size_o  = size_i;
  assign cfg_wdata_o = wdata_i;

  assign irq_o        = ~msix_en_i & isr[0];
  assign notify_o     = notify_q;
  assign notify_idx_o = nidx_q;
  assign dev_rst_o    = rst_q;

  always_comb begin
    rdata_o = '1;
    if (!hdr) rdata_o = cfg_rdata_i;
    else begin
      case (addr_i)
        A_HFEAT: rdata_o = dev_feat_i | FIXED_FEAT;
        A_GFEAT: rdata_o = gfeat;
        A_PFN:   rdata_o = pfn[qsel];
        A_QSZ:   rdata_o = {16'h0, QSZ16};
        A_QSEL:  rdata_o = 32'(qsel);
        A_STAT:  rdata_o = {24'h0, status};
        A_ISR:   rdata_o = {24'h0, isr};
        A_CVEC:  if (msix_en_i) rdata_o = {16'h0, cvec};
        A_QVEC:  if (msix_en_i) rdata_o = {16'h0, qvec[qsel]};
        default: rdata_o = '1;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gfeat  <= '0;
      cvec   <= NO_VEC;
      qsel   <= '0;
      status <= '0;
      isr    <= '0;
      for (int i = 0; i < NUM_Q; i++) begin
        pfn[i]  <= '0;
        qvec[i] <= NO_VEC;
      end
    end else if (dev_clr) begin
      gfeat  <= '0;
      cvec   <= NO_VEC;
      qsel   <= '0;
      status <= '0;
      isr    <= '0;
      for (int i = 0; i < NUM_Q; i++) begin
        pfn[i]  <= '0;
        qvec[i] <= NO_VEC;
      end
    end else begin
      isr <= ((rd && addr_i == A_ISR) ? 8'h00 : isr) | isr_set;
      if (wr) begin
        case (addr_i)
          A_GFEAT: gfeat <= wdata_i[BAD_BIT] ? fallback_feat_i : wdata_i;
          A_PFN:   pfn[qsel] <= wdata_i;
          A_QSEL:  if (wdata_i < NQ32) qsel <= wdata_i[QW-1:0];
          A_STAT:  status <= wdata_i[7:0];
          A_CVEC:  if (msix_en_i) cvec <= vec_ok ? vec_val : NO_VEC;
          A_QVEC:  if (msix_en_i) qvec[qsel] <= vec_ok ? vec_val : NO_VEC;
          default: ;
        endcase
      end
      if (bm_off_i) begin
        if (wr && addr_i == A_STAT) status <= wdata_i[7:0] & ~(8'd1 << DRV_OK);
        else status[DRV_OK] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      notify_q <= 1'b0;
      nidx_q   <= '0;
      rst_q    <= 1'b0;
    end else begin
      notify_q <= wr && addr_i == A_NOTE;
      if (wr && addr_i == A_NOTE) nidx_q <= wdata_i[15:0];
      rst_q <= dev_clr;
    end
  end

  a_r4_reset_clears: assert property (@(posedge clk) disable iff (!rst_n)
    dev_rst_o |-> (status == 8'h0 && isr == 8'h0 && gfeat == 32'h0 && qsel == '0));
  a_r6_isr_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && addr_i == A_ISR && !q_intr_i && !cfg_chg_i) |=> isr == 8'h0);
  a_r7_irq_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && addr_i == A_ISR && !q_intr_i && !cfg_chg_i) |=> !irq_o);
  a_r8_notify_src: assert property (@(posedge clk) disable iff (!rst_n)
    notify_o |-> $past(wr && addr_i == A_NOTE));
  a_r3_qsel_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr_i == A_QSEL && wdata_i >= NQ32) |=> $stable(qsel));
  a_r9_bad_vec: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && msix_en_i && addr_i == A_CVEC && !vec_ok) |=> cvec == NO_VEC);
  a_r5_bm_off: assert property (@(posedge clk) disable iff (!rst_n)
    bm_off_i |=> !status[DRV_OK]);
endmodule

// File: tb/vio_regbank_bench.sv
module vio_regbank_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 21;

  logic clk = 0, rst_n = 0;
  logic req = 0, we = 0, msix = 0, qi = 0, cc = 0, bm = 0;
  logic [7:0] addr = 0;
  logic [31:0] wdata = 0, rdata, cfg_wdata, cfg_rdata;
  logic irq, ntf, drst, creq, cwe;
  logic [15:0] nidx;
  logic [7:0] caddr;
  logic [1:0] csize;
  int n_chk = 0, n_fail = 0;
  logic [31:0] rd_val;
  logic rd_creq;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign cfg_rdata = 32'hAB00_0000 | 32'(caddr);

  vio_regbank u_vio_regbank (
    .clk(clk), .rst_n(rst_n), .req_i(req), .we_i(we), .addr_i(addr), .size_i(2'd2),
    .wdata_i(wdata), .rdata_o(rdata), .msix_en_i(msix), .dev_feat_i(32'h0000_0021),
    .fallback_feat_i(32'h0000_0001), .q_intr_i(qi), .cfg_chg_i(cc), .bm_off_i(bm),
    .irq_o(irq), .notify_o(ntf), .notify_idx_o(nidx), .dev_rst_o(drst),
    .cfg_req_o(creq), .cfg_we_o(cwe), .cfg_addr_o(caddr), .cfg_size_o(csize),
    .cfg_wdata_o(cfg_wdata), .cfg_rdata_i(cfg_rdata));

  // {req tag, we, addr, data (write value or expected read)}
  localparam logic [44:0] VEC [NV] = '{
    {4'd1, 1'b0, 8'd0,  32'h5100_0021},  // R1 host features
    {4'd2, 1'b1, 8'd4,  32'h0000_0005},  // R2
    {4'd2, 1'b0, 8'd4,  32'h0000_0005},
    {4'd2, 1'b1, 8'd4,  32'h4000_0003},  // R2 bad-feature bit
    {4'd2, 1'b0, 8'd4,  32'h0000_0001},
    {4'd3, 1'b1, 8'd14, 32'h0000_0002},  // R3
    {4'd3, 1'b1, 8'd8,  32'h0000_1234},
    {4'd3, 1'b0, 8'd8,  32'h0000_1234},
    {4'd3, 1'b0, 8'd12, 32'h0000_0080},
    {4'd3, 1'b1, 8'd14, 32'h0000_0004},  // R3 out of range
    {4'd3, 1'b0, 8'd14, 32'h0000_0002},
    {4'd3, 1'b1, 8'd14, 32'h0000_0000},
    {4'd3, 1'b0, 8'd8,  32'h0000_0000},
    {4'd5, 1'b1, 8'd18, 32'h0000_0107},  // R5 low byte kept
    {4'd5, 1'b0, 8'd18, 32'h0000_0007},
    {4'd10, 1'b0, 8'd1, 32'hFFFF_FFFF},  // R10 unmapped
    {4'd10, 1'b0, 8'd17, 32'hFFFF_FFFF},
    {4'd1, 1'b1, 8'd0,  32'h0000_0000},  // R1 write dropped
    {4'd1, 1'b0, 8'd0,  32'h5100_0021},
    {4'd10, 1'b0, 8'd21, 32'hAB00_0001}, // R10 window at 20
    {4'd9, 1'b0, 8'd20, 32'hAB00_0000}   // R9 no vectors when disabled
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic acc(input logic w, input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    req = 1; we = w; addr = a; wdata = d;
    #1 rd_val = rdata; rd_creq = creq;
    @(posedge clk); #1;
    req = 0; we = 0;
  endtask

  task automatic cyc;
    @(posedge clk); #1;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_fail++; n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 3) rst_n = 1;
    // R4 reset state
    check("R4 reset irq", 32'(irq), 0);
    check("R8 reset notify", 32'(ntf), 0);
    acc(0, 8'd18, 0); check("R4 reset status", rd_val, 0);

    for (int i = 0; i < NV; i++) begin
      acc(VEC[i][40], VEC[i][39:32], VEC[i][31:0]);
      if (!VEC[i][40]) check($sformatf("R%0d vector %0d", VEC[i][44:41], i), rd_val, VEC[i][31:0]);
    end

    // R6 / R7 queue event then read-clear
    @(negedge clk); qi = 1; cyc(); qi = 0;
    check("R7 irq follows isr", 32'(irq), 1);
    acc(0, 8'd19, 0); check("R6 isr read", rd_val, 1);
    check("R7 irq drops after read", 32'(irq), 0);
    acc(0, 8'd19, 0); check("R6 isr cleared", rd_val, 0);
    // R6 event in same cycle as read
    @(negedge clk); cc = 1; req = 1; addr = 8'd19; #1 rd_val = rdata;
    cyc(); cc = 0; req = 0;
    check("R6 read during event", rd_val, 0);
    acc(0, 8'd19, 0); check("R6 event kept", rd_val, 3);
    // R7 MSI-X on masks legacy line
    msix = 1;
    @(negedge clk); qi = 1; cyc(); qi = 0;
    check("R7 irq masked", 32'(irq), 0);
    acc(0, 8'd19, 0); check("R6 isr set under msix", rd_val, 1);

    // R9 vectors
    acc(0, 8'd20, 0); check("R9 cvec reset", rd_val, 32'hFFFF);
    acc(1, 8'd20, 2); acc(0, 8'd20, 0); check("R9 cvec ok", rd_val, 2);
    acc(1, 8'd20, 3); acc(0, 8'd20, 0); check("R9 cvec bad", rd_val, 32'hFFFF);
    acc(1, 8'd14, 2); acc(1, 8'd22, 1); acc(0, 8'd22, 0); check("R9 qvec ok", rd_val, 1);
    acc(1, 8'd14, 1); acc(0, 8'd22, 0); check("R9 qvec per queue", rd_val, 32'hFFFF);
    acc(1, 8'd14, 2); acc(1, 8'd22, 9); acc(0, 8'd22, 0); check("R9 qvec bad", rd_val, 32'hFFFF);
    acc(0, 8'd24, 0); check("R10 window at 24", rd_val, 32'hAB00_0000);
    check("R10 window strobe", 32'(rd_creq), 1);
    acc(0, 8'd20, 0); check("R10 no strobe in header", 32'(rd_creq), 0);

    // R8 notify
    acc(1, 8'd16, 32'h0003_0003);
    check("R8 notify pulse", 32'(ntf), 1);
    check("R8 notify idx", 32'(nidx), 3);
    cyc(); check("R8 notify single", 32'(ntf), 0);
    acc(0, 8'd18, 0); check("R8 status unchanged", rd_val, 7);

    // R5 bus master off
    @(negedge clk); bm = 1; cyc(); bm = 0;
    acc(0, 8'd18, 0); check("R5 driver-ok cleared", rd_val, 3);

    // R4 status zero reset (0x100: low byte zero)
    acc(1, 8'd20, 1);
    acc(1, 8'd4, 5); acc(1, 8'd14, 2); acc(1, 8'd8, 32'h77);
    acc(1, 8'd18, 32'h100);
    check("R4 reset pulse", 32'(drst), 1);
    cyc(); check("R4 reset pulse single", 32'(drst), 0);
    acc(0, 8'd4, 0); check("R4 gfeat cleared", rd_val, 0);
    acc(0, 8'd14, 0); check("R4 qsel cleared", rd_val, 0);
    acc(0, 8'd20, 0); check("R4 cvec to none", rd_val, 32'hFFFF);
    acc(1, 8'd14, 2); acc(0, 8'd8, 0); check("R4 pfn cleared", rd_val, 0);
    // R4 zero PFN reset
    acc(1, 8'd4, 9); acc(1, 8'd8, 0);
    check("R4 pfn-zero pulse", 32'(drst), 1);
    acc(0, 8'd4, 0); check("R4 pfn-zero clears", rd_val, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule